// File: doc/BRIEF.md
# Eight-Output Addressable Latch and Demultiplexer

This block holds an eight-bit parallel word in which any single bit can be written by address, and it doubles as a one-of-eight decoder. A 3-bit address, one data bit and two active-low controls (enable and clear) are sampled on each rising clock edge. The two controls pick one of four modes: write the addressed bit, hold the whole word, decode the data bit onto the addressed output with the others forced low, or clear everything.

It suits serial-to-parallel loading, where bits arrive one at a time with their positions, and steering one signal to one of eight destinations. A monitor watches how the address is handled around writes. It raises a one-cycle violation flag when the address jumps by more than one bit during a write, or when enable is asserted before the address has been steady for a set number of cycles. The flag only reports. The write still takes place.

Top module: `addr_latch`

## Requirements
- R1: While rst_ni is low, q_o and viol_o are all zero.
- R2: With en_ni=0 and clr_ni=1 (write mode), the edge loads data_i into bit addr_i of q_o. Every other bit of q_o keeps its value.
- R3: With en_ni=1 and clr_ni=1 (hold mode), q_o keeps its value on the edge, whatever addr_i and data_i are.
- R4: With en_ni=0 and clr_ni=0 (decode mode), the edge sets bit addr_i of q_o to data_i and every other bit to 0.
- R5: With en_ni=1 and clr_ni=0 (clear mode), the edge sets all of q_o to 0, whatever addr_i and data_i are.
- R6: Address value n selects bit n of q_o, where bit 0 is the least significant. For example, address 5 in decode mode with data 1 gives q_o = 8'h20.
- R7: A sample in write mode whose addr_i differs from the previous edge's addr_i in two or more bit positions raises viol_o for the following cycle.
- R8: Enable is asserted when en_ni is 0 at an edge and was 1 at the previous edge. If, at that moment, addr_i has not matched the sampled address on each of the SETUP_CYCLES (default 2) preceding edges since reset, viol_o is raised for the following cycle. The write or decode still takes effect.
- R9: When decode mode is followed by hold mode, q_o keeps the pattern from the last decode cycle.
- R10: In any cycle where neither the R7 condition nor the R8 condition held at the previous edge, viol_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Selects the output bit |
| data_i | input | 1 | Bit value to write or decode |
| en_ni | input | 1 | Enable, active low |
| clr_ni | input | 1 | Clear, active low |
| q_o | output | 8 | Parallel output word |
| viol_o | output | 1 | One-cycle address-handling violation flag |

## Verification
A single write-mode edge can trigger both the multi-bit-jump check and the setup shortfall check, and it still has to update its addressed bit in that same cycle. The bench produces this by moving the address by two or more bits in exactly the cycle where enable falls. It then checks that viol_o rises once and that q_o reflects the write. Directed sequences also set a decode cycle right beside a hold cycle, and a clear right after a write, to confirm that the mode switch and the violation flag do not interfere with each other.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_DECODE = 2'b10,
    MODE_CLEAR  = 2'b11
  } lat_mode_e;

  function automatic lat_mode_e pick_mode(logic en_n, logic clr_n);
    case ({en_n, clr_n})
      2'b01:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DECODE;
      default: return MODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/addr_latch_core.sv
module addr_latch_core
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lat_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  output logic [N_OUT-1:0]  q_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    logic hit;
    logic nxt;
    assign hit = (addr_i == ADDR_W'(i));
    always_comb begin
      case (mode_i)
        MODE_WRITE:  nxt = hit ? data_i : q_o[i];
        MODE_HOLD:   nxt = q_o[i];
        MODE_DECODE: nxt = hit & data_i;
        default:     nxt = 1'b0;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= nxt;
    end
  end

  p_write_others_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_WRITE) |=>
      (((q_o ^ $past(q_o)) & ~(N_OUT'(1) << $past(addr_i))) == '0));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(q_o));
  p_decode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DECODE) |=>
      (q_o == ($past(data_i) ? (N_OUT'(1) << $past(addr_i)) : '0)));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CLEAR) |=> (q_o == '0));
endmodule

// File: rtl/addr_latch_mon.sv
module addr_latch_mon #(
  parameter int ADDR_W       = 3,
  parameter int SETUP_CYCLES = 2,
  localparam int CNT_W = $clog2(SETUP_CYCLES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_ni,
  input  logic              clr_ni,
  output logic              viol_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(SETUP_CYCLES);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  run_q, run_d;
  logic              en_q;
  logic              jump, short_setup;

  // previous address is sampled every edge, reset included
  always_ff @(posedge clk_i) addr_q <= addr_i;

  always_comb begin
    if (addr_i != addr_q)    run_d = '0;
    else if (run_q >= RUN_MAX) run_d = RUN_MAX;
    else                     run_d = run_q + 1'b1;
  end

  assign jump        = !en_ni && clr_ni && ($countones(addr_i ^ addr_q) > 1);
  assign short_setup = en_q && !en_ni && (run_d < RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      en_q   <= 1'b1;
      viol_o <= 1'b0;
    end else begin
      run_q  <= run_d;
      en_q   <= en_ni;
      viol_o <= jump | short_setup;
    end
  end

  p_jump_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_ni && ($countones(addr_i ^ $past(addr_i)) > 1)) |=> viol_o);
  p_setup_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((SETUP_CYCLES > 0) && $past(en_ni) && !en_ni && (addr_i != $past(addr_i))) |=> viol_o);
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && clr_ni) |=> !viol_o);
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int SETUP_CYCLES = 2,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  input  logic              en_ni,
  input  logic              clr_ni,
  output logic [N_OUT-1:0]  q_o,
  output logic              viol_o
);
  lat_mode_e mode;
  assign mode = pick_mode(en_ni, clr_ni);

  addr_latch_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .addr_i (addr_i),
    .data_i (data_i),
    .q_o    (q_o)
  );

  addr_latch_mon #(.ADDR_W(ADDR_W), .SETUP_CYCLES(SETUP_CYCLES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .viol_o (viol_o)
  );

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0) && !viol_o);
endmodule

// File: tb/addr_latch_test.sv
module addr_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP      = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic       data = 1'b0, en_n = 1'b1, clr_n = 1'b1;
  logic [7:0] q;
  logic       viol;

  int checks = 0, errors = 0;

  logic [7:0] m_q = '0;
  logic       m_viol = 1'b0;
  logic [2:0] m_prev = '0;
  int         m_run = 0;
  logic       m_en_prev = 1'b1;
  string      tag_q = "R1", tag_v = "R1";

  addr_latch #(.ADDR_W(3), .SETUP_CYCLES(SETUP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data),
    .en_ni(en_n), .clr_ni(clr_n), .q_o(q), .viol_o(viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int next_run(logic [2:0] a);
    if (a != m_prev) return 0;
    return (m_run + 1 > SETUP) ? SETUP : m_run + 1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, predict, then check at the next falling edge
  task automatic step(logic [2:0] a, logic d, logic e, logic c);
    int run;
    logic jump, shrt;
    addr = a; data = d; en_n = e; clr_n = c;
    run  = next_run(a);
    jump = !e && c && ($countones(a ^ m_prev) > 1);
    shrt = m_en_prev && !e && (run < SETUP);
    case ({e, c})
      2'b01: begin m_q[a] = d; tag_q = "R2"; end
      2'b11: tag_q = "R3";
      2'b00: begin m_q = d ? (8'b1 << a) : 8'h00; tag_q = "R4"; end
      default: begin m_q = 8'h00; tag_q = "R5"; end
    endcase
    m_viol = jump | shrt;
    tag_v = jump ? "R7" : (shrt ? "R8" : "R10");
    m_prev = a; m_run = run; m_en_prev = e;
    @(negedge clk);
    chk(tag_q, q, m_q);
    chk(tag_v, {7'b0, viol}, {7'b0, m_viol});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", q, 8'h00);
    chk("R1", {7'b0, viol}, 8'h00);
    rst_ni = 1'b1;

    // R6: address 5 decoded, preceded by a settled address
    step(3'd5, 0, 1, 1); step(3'd5, 0, 1, 1); step(3'd5, 0, 1, 1);
    step(3'd5, 1, 0, 0);
    chk("R6", q, 8'h20);
    // R9: decode then hold keeps the pattern
    step(3'd2, 1, 1, 1);
    chk("R9", q, 8'h20);
    step(3'd0, 0, 1, 1);
    chk("R9", q, 8'h20);
    // R2: settled writes, single-bit moves
    step(3'd0, 0, 1, 1); step(3'd0, 0, 1, 1);
    step(3'd0, 1, 0, 1);
    step(3'd1, 1, 0, 1);
    chk("R2", q, 8'h23);
    // R7: two-bit jump while writing
    step(3'd7, 1, 0, 1);
    chk("R7", {7'b0, viol}, 8'h01);
    chk("R2", q, 8'ha3);
    // R7 and R8 together: enable falls with a jumping address
    step(3'd7, 0, 1, 1);
    step(3'd4, 1, 0, 1);
    chk("R8", {7'b0, viol}, 8'h01);
    chk("R8", q, 8'hb3);
    // R8: enable falls one cycle after an address change
    step(3'd6, 0, 1, 1);
    step(3'd6, 1, 0, 1);
    chk("R8", {7'b0, viol}, 8'h01);
    // R5: clear ignores data and address
    step(3'd3, 1, 1, 0);
    chk("R5", q, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 6) ? (m_prev ^ (3'b1 << $urandom_range(0, 2))) :
          (r < 8) ? m_prev : 3'($urandom_range(0, 7));
      r = $urandom_range(0, 9);
      step(a, 1'($urandom_range(0, 1)),
           (r < 5) ? 1'b1 : 1'b0,
           (r < 3 || r >= 9) ? 1'b0 : 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule